// File: doc/BRIEF.md
# Packet Header Framer

This block turns a stream of 32-bit samples into 64-bit packets. Each packet starts with a header word. A timestamp word follows when the header asks for one, and then the samples come packed two to a word. The upstream stage marks the last sample of each packet with `s_last`. It also supplies a 128-bit sideband: the upper 64 bits are a header template and the lower 64 bits are a timestamp.

The byte length in the header covers the whole packet, so it is not known until the last sample has arrived. For that reason the payload words are held in a ring buffer. A per-packet descriptor, carrying the rewritten header, the timestamp and the word count, is queued beside the buffer. The emitter sends a packet only after its descriptor exists. It fills in either an internally generated rolling sequence number or the one carried in the sideband.

A synchronous clear flushes every buffered word and descriptor and restarts the internal sequence count. Packets must not exceed the buffer capacity of `2**BUF_AW` words.

Top module: `pkt_hdr_framer`

## Requirements
- R1: The output header word carries these sideband fields in place: packet kind (`s_side[127:126]`) at bits [63:62], has-time (`s_side[125]`) at [61], end-of-burst (`s_side[124]`) at [60], source id (`s_side[95:80]`) at [31:16] and destination id (`s_side[79:64]`) at [15:0]. The sideband length field `s_side[111:96]` is not used.
- R2: With has-time clear, header bits [47:32] hold 4 × (sample count) + 8, and the payload follows the header directly.
- R3: With has-time set, the second output word is `s_side[63:0]` and the length is 4 × (sample count) + 16.
- R4: Payload word k holds sample 2k in bits [63:32] and sample 2k+1 in bits [31:0]. After an odd sample count, bits [31:0] of the last word are zero.
- R5: With `USE_SIDE_SEQ`=0, header bits [59:48] are 0 for the first packet after reset and increase by one per emitted packet, wrapping from 4095 to 0.
- R6: With `USE_SIDE_SEQ`=1, header bits [59:48] equal `s_side[123:112]` of the packet.
- R7: A `clr` pulse discards all buffered data. In the next cycle `m_valid` is low and `s_ready` is high, and the next packet carries internal sequence number 0.
- R8: `s_ready` is low while the payload buffer holds `2**BUF_AW` words or the descriptor queue is full. No accepted sample is lost.
- R9: `m_last` is high on the final payload word only and never on a header or timestamp word. While `m_valid` is high and `m_ready` is low, `m_data` and `m_last` hold steady.
- R10: The sideband is sampled with the first sample of a packet. Sideband changes during later samples of the same packet have no effect.
- R11: After reset, `m_valid` is low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous flush and sequence restart |
| s_data | input | 32 | Input sample |
| s_last | input | 1 | Last sample of the packet |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted when high with `s_valid` |
| s_side | input | 128 | Header template [127:64] and timestamp [63:0] |
| m_data | output | 64 | Output packet word |
| m_last | output | 1 | Final word of the packet |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream accepts the word |

## Verification
A wrong packer state, such as a stale half word or a miscounted sample total, appears at the ports as a shifted payload word or a wrong length field. It becomes visible as soon as that packet is emitted, which is one cycle after its last sample is accepted. A sequence counter that skips or sticks shows in the header of the very next packet, and the wrap is reached by a run of more than four thousand short packets. Errors in buffer occupancy show as `s_ready` staying high on a full buffer, or as words lost or duplicated once the buffer drains.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;

    localparam int SAMP_W = 32;
    localparam int WORD_W = 64;
    localparam int SIDE_W = 128;
    localparam int CNT_W  = 16;

    // Output header word, MSB first
    typedef struct packed {
        logic [1:0]  kind;
        logic        has_ts;
        logic        eob;
        logic [11:0] seq;
        logic [15:0] len;
        logic [15:0] src;
        logic [15:0] dst;
    } hdr_t;

    // One finished packet waiting for emission
    typedef struct packed {
        hdr_t              hdr;
        logic [63:0]       ts;
        logic [CNT_W-1:0]  nwords;
    } desc_t;

    typedef enum logic [1:0] {
        EM_HDR = 2'd0,
        EM_TS  = 2'd1,
        EM_PAY = 2'd2
    } em_state_t;

    // Total byte length of a packet: payload plus header (and timestamp)
    function automatic logic [15:0] pkt_bytes(input logic [CNT_W-1:0] nsamp,
                                              input logic has_ts);
        logic [15:0] extra;
        extra = has_ts ? 16'd16 : 16'd8;
        return 16'((nsamp << 2) + extra);
    endfunction

endpackage

// File: rtl/pf_fifo.sv
module pf_fifo #(
    parameter int W  = 64,
    parameter int AW = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wptr, rptr;
    logic [AW:0]  used;

    assign used  = wptr - rptr;
    assign empty = (used == '0);
    assign full  = (used == (AW+1)'(DEPTH));
    assign dout  = mem[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full)
            mem[wptr[AW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push && !full)
                wptr <= wptr + 1'b1;
            if (pop && !empty)
                rptr <= rptr + 1'b1;
        end
    end
endmodule

// File: rtl/pf_packer.sv
module pf_packer
    import pkt_framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [SAMP_W-1:0] s_data,
    input  logic              s_last,
    input  logic [SIDE_W-1:0] s_side,
    input  logic              accept,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_word,
    output logic              desc_push,
    output desc_t             desc
);
    logic              in_pkt;
    logic              half_v;
    logic [SAMP_W-1:0] half_q;
    logic [CNT_W-1:0]  samp_cnt;
    logic [CNT_W-1:0]  word_cnt;
    logic [SIDE_W-1:0] side_q;

    logic [SIDE_W-1:0] side_now;
    logic [CNT_W-1:0]  samp_nxt;
    hdr_t              tmpl;

    assign side_now = in_pkt ? side_q : s_side;
    assign samp_nxt = samp_cnt + 1'b1;
    assign tmpl     = hdr_t'(side_now[127:64]);

    assign wr_en   = accept && (half_v || s_last);
    assign wr_word = half_v ? {half_q, s_data} : {s_data, {SAMP_W{1'b0}}};

    assign desc_push = accept && s_last;

    always_comb begin
        desc          = '0;
        desc.hdr      = tmpl;
        desc.hdr.len  = pkt_bytes(samp_nxt, tmpl.has_ts);
        desc.ts       = side_now[63:0];
        desc.nwords   = word_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            in_pkt   <= 1'b0;
            half_v   <= 1'b0;
            half_q   <= '0;
            samp_cnt <= '0;
            word_cnt <= '0;
            side_q   <= '0;
        end else if (accept) begin
            if (s_last) begin
                in_pkt   <= 1'b0;
                half_v   <= 1'b0;
                samp_cnt <= '0;
                word_cnt <= '0;
            end else begin
                in_pkt   <= 1'b1;
                samp_cnt <= samp_nxt;
                if (!in_pkt)
                    side_q <= s_side;
                if (half_v) begin
                    half_v   <= 1'b0;
                    word_cnt <= word_cnt + 1'b1;
                end else begin
                    half_v <= 1'b1;
                    half_q <= s_data;
                end
            end
        end
    end
endmodule

// File: rtl/pf_emitter.sv
module pf_emitter
    import pkt_framer_pkg::*;
#(
    parameter bit USE_SIDE_SEQ = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  desc_t             desc,
    input  logic              desc_valid,
    output logic              desc_pop,
    input  logic [WORD_W-1:0] pay_word,
    input  logic              pay_valid,
    output logic              pay_pop,
    output logic [WORD_W-1:0] m_data,
    output logic              m_last,
    output logic              m_valid,
    input  logic              m_ready
);
    em_state_t        state;
    logic [CNT_W-1:0] remain;
    logic [11:0]      seq_q;
    hdr_t             hdr_o;
    logic             fire;

    generate
        if (USE_SIDE_SEQ) begin : g_side_seq
            assign hdr_o = desc.hdr;
        end else begin : g_own_seq
            always_comb begin
                hdr_o     = desc.hdr;
                hdr_o.seq = seq_q;
            end
        end
    endgenerate

    always_comb begin
        m_valid = 1'b0;
        m_last  = 1'b0;
        m_data  = '0;
        unique case (state)
            EM_HDR: begin
                m_valid = desc_valid;
                m_data  = hdr_o;
            end
            EM_TS: begin
                m_valid = 1'b1;
                m_data  = desc.ts;
            end
            EM_PAY: begin
                m_valid = pay_valid;
                m_data  = pay_word;
                m_last  = (remain == CNT_W'(1));
            end
            default: ;
        endcase
    end

    assign fire     = m_valid && m_ready;
    assign pay_pop  = fire && (state == EM_PAY);
    assign desc_pop = pay_pop && m_last;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state  <= EM_HDR;
            remain <= '0;
            seq_q  <= '0;
        end else if (fire) begin
            unique case (state)
                EM_HDR: begin
                    seq_q  <= seq_q + 1'b1;
                    remain <= desc.nwords;
                    state  <= desc.hdr.has_ts ? EM_TS : EM_PAY;
                end
                EM_TS: state <= EM_PAY;
                EM_PAY: begin
                    remain <= remain - 1'b1;
                    if (m_last)
                        state <= EM_HDR;
                end
                default: state <= EM_HDR;
            endcase
        end
    end
endmodule

// File: rtl/pkt_hdr_framer.sv
module pkt_hdr_framer
    import pkt_framer_pkg::*;
#(
    parameter int BUF_AW       = 10,
    parameter int DESC_AW      = 2,
    parameter bit USE_SIDE_SEQ = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [31:0]  s_data,
    input  logic         s_last,
    input  logic         s_valid,
    output logic         s_ready,
    input  logic [127:0] s_side,
    output logic [63:0]  m_data,
    output logic         m_last,
    output logic         m_valid,
    input  logic         m_ready
);
    localparam int DESC_W = $bits(desc_t);

    logic              accept;
    logic              wr_en, desc_push;
    logic [WORD_W-1:0] wr_word, pay_word;
    desc_t             desc_in, desc_out;
    logic [DESC_W-1:0] desc_raw;
    logic              pay_empty, pay_full, desc_empty, desc_full;
    logic              pay_pop, desc_pop;

    assign s_ready  = !pay_full && !desc_full;
    assign accept   = s_valid && s_ready;
    assign desc_out = desc_t'(desc_raw);

    pf_packer u_pack (
        .clk, .rst, .clr,
        .s_data, .s_last, .s_side,
        .accept,
        .wr_en, .wr_word,
        .desc_push, .desc(desc_in)
    );

    pf_fifo #(.W(WORD_W), .AW(BUF_AW)) u_pay (
        .clk, .rst, .clr,
        .push(wr_en), .din(wr_word),
        .pop(pay_pop), .dout(pay_word),
        .empty(pay_empty), .full(pay_full)
    );

    pf_fifo #(.W(DESC_W), .AW(DESC_AW)) u_desc (
        .clk, .rst, .clr,
        .push(desc_push), .din(desc_in),
        .pop(desc_pop), .dout(desc_raw),
        .empty(desc_empty), .full(desc_full)
    );

    pf_emitter #(.USE_SIDE_SEQ(USE_SIDE_SEQ)) u_emit (
        .clk, .rst, .clr,
        .desc(desc_out), .desc_valid(!desc_empty), .desc_pop,
        .pay_word, .pay_valid(!pay_empty), .pay_pop,
        .m_data, .m_last, .m_valid, .m_ready
    );
endmodule

// File: rtl/pkt_hdr_framer_chk.sv
module pkt_hdr_framer_chk #(
    parameter bit USE_SIDE_SEQ = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        clr,
    input logic        s_ready,
    input logic [63:0] m_data,
    input logic        m_last,
    input logic        m_valid,
    input logic        m_ready
);
    logic        first_beat;
    logic        have_prev;
    logic [11:0] prev_seq;
    logic        odd_q;
    logic [15:0] pay_bytes;

    assign pay_bytes = m_data[47:32] - (m_data[61] ? 16'd16 : 16'd8);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            first_beat <= 1'b1;
            have_prev  <= 1'b0;
            prev_seq   <= '0;
            odd_q      <= 1'b0;
        end else if (m_valid && m_ready) begin
            first_beat <= m_last;
            if (first_beat) begin
                have_prev <= 1'b1;
                prev_seq  <= m_data[59:48];
                odd_q     <= pay_bytes[2];
            end
        end
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst || clr)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));

    // R9
    hdr_not_last_chk: assert property (@(posedge clk) disable iff (rst || clr)
        m_valid && first_beat |-> !m_last);

    // R2
    len_sane_chk: assert property (@(posedge clk) disable iff (rst || clr)
        m_valid && first_beat |-> (m_data[33:32] == 2'b00) && (m_data[47:32] >= 16'd12));

    // R4
    odd_pad_chk: assert property (@(posedge clk) disable iff (rst || clr)
        m_valid && m_last && !first_beat && odd_q |-> m_data[31:0] == 32'h0);

    // R7
    clr_flush_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !m_valid && s_ready);

    generate
        if (!USE_SIDE_SEQ) begin : g_seq
            // R5
            seq_step_chk: assert property (@(posedge clk) disable iff (rst || clr)
                m_valid && first_beat && have_prev |-> m_data[59:48] == prev_seq + 12'd1);
        end
    endgenerate
endmodule

bind pkt_hdr_framer pkt_hdr_framer_chk #(.USE_SIDE_SEQ(USE_SIDE_SEQ)) u_chk (
    .clk(clk), .rst(rst), .clr(clr), .s_ready(s_ready),
    .m_data(m_data), .m_last(m_last), .m_valid(m_valid), .m_ready(m_ready)
);

// File: tb/tb_pkt_hdr_framer.sv
module tb_pkt_hdr_framer;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic         rst, clr;
    logic [31:0]  s_data;
    logic         s_last, s_valid;
    logic [127:0] s_side;
    logic         mrdy;
    logic         sel;      // 0: dut, 1: dut_s

    logic        a_ready, a_last, a_valid;
    logic [63:0] a_data;
    logic        b_ready, b_last, b_valid;
    logic [63:0] b_data;

    pkt_hdr_framer #(.BUF_AW(10), .USE_SIDE_SEQ(1'b0)) dut (
        .clk(clk), .rst(rst), .clr(clr),
        .s_data(s_data), .s_last(s_last), .s_valid(s_valid && !sel), .s_ready(a_ready),
        .s_side(s_side),
        .m_data(a_data), .m_last(a_last), .m_valid(a_valid), .m_ready(mrdy && !sel)
    );

    pkt_hdr_framer #(.BUF_AW(3), .USE_SIDE_SEQ(1'b1)) dut_s (
        .clk(clk), .rst(rst), .clr(clr),
        .s_data(s_data), .s_last(s_last), .s_valid(s_valid && sel), .s_ready(b_ready),
        .s_side(s_side),
        .m_data(b_data), .m_last(b_last), .m_valid(b_valid), .m_ready(mrdy && sel)
    );

    wire        x_ready = sel ? b_ready : a_ready;
    wire        x_valid = sel ? b_valid : a_valid;
    wire        x_last  = sel ? b_last  : a_last;
    wire [63:0] x_data  = sel ? b_data  : a_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [15:0] pbase = 16'h0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_side(input logic [1:0] kind, input logic ht, input logic eob,
                                             input logic [11:0] seq, input logic [15:0] src,
                                             input logic [15:0] dst, input logic [63:0] ts);
        return {kind, ht, eob, seq, 16'hBEEF, src, dst, ts};
    endfunction

    function automatic logic [31:0] samp(input int i);
        return {pbase, 16'(i)};
    endfunction

    // Drive one packet; side_late is shown from the second sample on
    task automatic send_pkt(input int n, input logic [127:0] side, input logic [127:0] side_late);
        for (int i = 0; i < n; i++) begin
            bit ok;
            s_data  = samp(i);
            s_last  = (i == n-1);
            s_valid = 1'b1;
            s_side  = (i == 0) ? side : side_late;
            ok = 0;
            while (!ok) begin
                ok = x_ready;
                @(negedge clk);
            end
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    // Collect one packet and compare it word by word
    task automatic recv_check(input int n, input logic [127:0] side, input logic [11:0] seq,
                              input bit bp, input string tag);
        logic [63:0] got[$];
        bit          lst[$];
        logic [63:0] exp[$];
        bit          fin = 0;
        int          cyc = 0;
        logic [63:0] h;
        int          nw;
        while (!fin && cyc < 5000) begin
            mrdy = bp ? ((cyc % 3) != 1) : 1'b1;
            #0;
            if (x_valid && mrdy) begin
                got.push_back(x_data);
                lst.push_back(x_last);
                fin = x_last;
            end
            @(negedge clk);
            cyc++;
        end
        mrdy = 1'b0;
        h = {side[127:124], seq, 16'(4*n + (side[125] ? 16 : 8)), side[95:64]};
        exp.push_back(h);
        if (side[125]) exp.push_back(side[63:0]);
        nw = (n + 1) / 2;
        for (int w = 0; w < nw; w++)
            exp.push_back({samp(2*w), (2*w+1 < n) ? samp(2*w+1) : 32'h0});
        chk(got.size() == exp.size(), {tag, " R9 word count"}, 64'(got.size()), 64'(exp.size()));
        if (got.size() == exp.size()) begin
            for (int k = 0; k < exp.size(); k++) begin
                string r;
                if (k == 0) r = "R1/R2/R5 header";
                else if (side[125] && k == 1) r = "R3 timestamp";
                else r = "R4 payload";
                chk(got[k] == exp[k], {tag, " ", r}, got[k], exp[k]);
                chk(lst[k] == (k == exp.size()-1), {tag, " R9 last flag"}, 64'(lst[k]), 64'(k == exp.size()-1));
            end
        end
        pbase = pbase + 16'h0101;
    endtask

    task automatic t_reset;
        chk(a_valid == 1'b0, "R11 m_valid after reset", 64'(a_valid), 64'd0);
        chk(a_ready == 1'b1, "R11 s_ready after reset", 64'(a_ready), 64'd1);
    endtask

    task automatic t_even;
        logic [127:0] sd = mk_side(2'b00, 1'b0, 1'b0, 12'h777, 16'h1111, 16'h2222, 64'h0);
        send_pkt(4, sd, sd);
        recv_check(4, sd, 12'd0, 0, "even R1 R2 R5");
    endtask

    task automatic t_odd_ts;
        logic [127:0] sd = mk_side(2'b10, 1'b1, 1'b1, 12'h123, 16'hA5A5, 16'h5A5A, 64'h0102030405060708);
        send_pkt(5, sd, sd);
        recv_check(5, sd, 12'd1, 0, "odd_ts R3 R4");
    endtask

    task automatic t_side_late;
        logic [127:0] sd  = mk_side(2'b01, 1'b0, 1'b0, 12'h0, 16'h3333, 16'h4444, 64'h0);
        logic [127:0] bad = mk_side(2'b11, 1'b1, 1'b1, 12'hFFF, 16'hDEAD, 16'hF00D, 64'hFFFF);
        send_pkt(3, sd, bad);
        recv_check(3, sd, 12'd2, 0, "late_side R10");
    endtask

    task automatic t_backpressure;
        logic [127:0] sd = mk_side(2'b00, 1'b1, 1'b0, 12'h0, 16'h0BAD, 16'hCAFE, 64'h1122334455667788);
        send_pkt(6, sd, sd);
        recv_check(6, sd, 12'd3, 1, "bp R9");
    endtask

    task automatic t_wrap;
        logic [127:0] sd = mk_side(2'b00, 1'b0, 1'b0, 12'h0, 16'h0001, 16'h0002, 64'h0);
        for (int s = 4; s <= 4096; s++) begin
            send_pkt(1, sd, sd);
            recv_check(1, sd, 12'(s), 0, "wrap R5");
        end
    endtask

    task automatic t_clear;
        logic [127:0] sd = mk_side(2'b00, 1'b0, 1'b0, 12'h0, 16'h00C1, 16'h00C2, 64'h0);
        send_pkt(2, sd, sd);
        chk(a_valid == 1'b1, "R7 packet pending before clear", 64'(a_valid), 64'd1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(a_valid == 1'b0, "R7 m_valid after clear", 64'(a_valid), 64'd0);
        chk(a_ready == 1'b1, "R7 s_ready after clear", 64'(a_ready), 64'd1);
        send_pkt(2, sd, sd);
        recv_check(2, sd, 12'd0, 0, "clear R7");
    endtask

    task automatic t_side_seq;
        logic [127:0] sd = mk_side(2'b00, 1'b1, 1'b0, 12'hABC, 16'h0E01, 16'h0E02, 64'hAAAA5555AAAA5555);
        sel = 1'b1;
        @(negedge clk);
        send_pkt(3, sd, sd);
        recv_check(3, sd, 12'hABC, 0, "side_seq R6");
    endtask

    task automatic t_full;
        logic [127:0] sd = mk_side(2'b00, 1'b0, 1'b0, 12'h05D, 16'h0F01, 16'h0F02, 64'h0);
        mrdy = 1'b0;
        send_pkt(16, sd, sd);   // exactly 8 words: buffer of dut_s is full
        s_valid = 1'b1;
        s_data  = 32'hFFFF_FFFF;
        #0;
        chk(b_ready == 1'b0, "R8 s_ready low on full buffer", 64'(b_ready), 64'd0);
        @(negedge clk);
        chk(b_ready == 1'b0, "R8 s_ready stays low", 64'(b_ready), 64'd0);
        s_valid = 1'b0;
        recv_check(16, sd, 12'h05D, 0, "full R8");
        chk(b_ready == 1'b1, "R8 s_ready back after drain", 64'(b_ready), 64'd1);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; clr = 1'b0; s_data = '0; s_last = 1'b0; s_valid = 1'b0;
        s_side = '0; mrdy = 1'b0; sel = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_even();
        t_odd_ts();
        t_side_late();
        t_backpressure();
        t_wrap();
        t_clear();
        t_side_seq();
        t_full();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule